// File: doc/BRIEF.md
# Single-Lane Link Training Controller

This block sequences one serial lane from power-up to an active link for a port that faces upstream. It watches the electrical-idle indication and a decoded stream of received training events. Each event is one ordered set, TS1 or TS2, with its link and lane fields (each either PAD or a number), an inverted-polarity flag and the disable-link control bit. A separate strobe marks each received idle symbol. From these events, and from a strobe that marks each ordered set or symbol the transmitter has finished, it tells the transmitter what to send and which link and lane numbers to put in it. It also drives the receive polarity inversion and reports link-up and the disabled condition.

Every step forward needs a number of events. Some steps count ordered sets received, some count ordered sets sent, and some count both. The configuration steps wait for the far end to fill in a link number and then a lane number, and the port sends each one back. Every polling and configuration state has a cycle timeout that returns the machine to the quiet detect state.

Top module: `lnk_train_fsm`

## Requirements
- R1: After reset the machine waits in a quiet detect state and sends nothing (`tx_kind_o` = 0) while `elec_idle_i` is high. When the idle indication drops it performs receiver detection for one cycle: with `rx_det_i` high it enters active polling, otherwise it returns to quiet detect.
- R2: Active polling sends TS1 (`tx_kind_o` = 1) with both fields PAD. It moves to polling configuration (TS2, `tx_kind_o` = 2, both fields PAD) only once both counts are met: at least TS1_TX_MIN (1024) `tx_done_i` cycles, and at least TS_RX_MIN (8) TS1 received, inverted or not. The two counts may be met in either order.
- R3: A TS1 received in active polling with `rx_os_inv_i` set raises `rx_invert_o`. The flag stays unchanged through all later states and clears only in quiet detect.
- R4: Polling configuration counts received TS2. It counts `tx_done_i` only in cycles after the first TS2 has been received. It advances to link-width start after 8 TS2 received and 16 counted sends.
- R5: Link-width start sends TS1 with both fields PAD. After two consecutive TS1 whose link field is not PAD, it captures that link number and moves to link-width accept. In that state it sends TS1 with the captured link number and a PAD lane field.
- R6: In link-width accept, two consecutive TS1 that carry both a link and a lane number capture the lane number. The machine then enters lane-number wait, which sends TS1 with both numbers echoed. Two consecutive TS2 then move it to config-complete, which sends TS2 with both numbers.
- R7: Config-complete moves to config-idle after 8 consecutive TS2 received. Config-idle sends idle symbols (`tx_kind_o` = 3) with `link_up_o` low.
- R8: Config-idle enters the link-up state (`link_up_o` high, `tx_kind_o` = 3) after 8 idle symbols have been received and 16 `tx_done_i` cycles have been counted after the first idle symbol was received.
- R9: Two consecutive TS1 with `rx_os_disable_i` set, received in any polling, configuration or link-up state, force the disabled state. That state raises `disabled_o`, sends nothing, and is left only by reset.
- R10: Remaining in any single polling or configuration state for TIMEOUT_CYC (4096) cycles returns the machine to quiet detect.
- R11: In the states that need consecutive sets, any received ordered set that does not match restarts the count from zero.
- R12: Synchronous active-low reset gives `tx_kind_o` = 0, `link_up_o` = 0, `disabled_o` = 0 and `rx_invert_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| elec_idle_i | input | 1 | Receiver sees electrical idle |
| rx_det_i | input | 1 | Receiver-detection result, far end present |
| rx_os_valid_i | input | 1 | One decoded ordered set this cycle |
| rx_os_is_ts2_i | input | 1 | Ordered set is TS2 (else TS1) |
| rx_os_link_pad_i | input | 1 | Link field is PAD |
| rx_os_link_i | input | 8 | Link number field |
| rx_os_lane_pad_i | input | 1 | Lane field is PAD |
| rx_os_lane_i | input | 8 | Lane number field |
| rx_os_inv_i | input | 1 | Set arrived with inverted polarity |
| rx_os_disable_i | input | 1 | Disable-link control bit |
| rx_idl_i | input | 1 | One idle symbol received this cycle |
| tx_done_i | input | 1 | Transmitter finished one set or symbol |
| tx_kind_o | output | 2 | 0 nothing, 1 TS1, 2 TS2, 3 idle symbols |
| tx_link_pad_o | output | 1 | Send PAD in link field |
| tx_link_o | output | 8 | Link number to send |
| tx_lane_pad_o | output | 1 | Send PAD in lane field |
| tx_lane_o | output | 8 | Lane number to send |
| rx_invert_o | output | 1 | Invert receive polarity |
| link_up_o | output | 1 | Link is up |
| disabled_o | output | 1 | Link disabled |

## Verification
The hardest conditions to reach from the ports are the ones that sit deep in the sequence: the counted-after-first-received rules in polling configuration and config-idle, and the restart of a consecutive count in config-complete. To reach them the bench first walks the lane through every earlier state with explicit ordered sets. It then delivers sends before the first received set, a non-matching set in the middle of a run, or exactly one send short of the limit. It checks the transmit request at each step, which is the only view of the state from outside. The timeout is reached by stopping all stimulus once polling has started.

// File: rtl/lnk_train_pkg.sv
// Shared types for the link training controller.
// Assumes: one lane, one ordered set per rx_os_valid_i pulse.
package lnk_train_pkg;

    typedef enum logic [3:0] {
        ST_DET_QUIET,
        ST_DET_ACTIVE,
        ST_POLL_ACTIVE,
        ST_POLL_CONFIG,
        ST_CFG_LW_START,
        ST_CFG_LW_ACCEPT,
        ST_CFG_LN_WAIT,
        ST_CFG_COMPLETE,
        ST_CFG_IDLE,
        ST_L0,
        ST_DISABLED
    } lt_state_e;

    typedef enum logic [1:0] {
        TXK_NONE = 2'd0,
        TXK_TS1  = 2'd1,
        TXK_TS2  = 2'd2,
        TXK_IDL  = 2'd3
    } lt_txkind_e;

endpackage

// File: rtl/lt_event_counter.sv
// Saturating event counter with synchronous clear.
// Assumes: clear wins over increment; the count holds at its maximum.
module lt_event_counter #(
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

    // count events, clearing on request and holding at the top
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (inc && count != MAXV)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/lt_timer.sv
// Cycle timer that flags expiry after LIMIT cycles of run.
// Assumes: clr restarts the count; expired is high in the LIMIT-th run cycle.
module lt_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt_q;

    // count cycles while running
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (run && cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/lnk_train_fsm.sv
// Single-lane training and status controller for an upstream-facing port.
// Consumes decoded ordered-set events, electrical idle and transmit-done
// strobes; requests the ordered set to send with its link/lane fields.
// Assumes: counters hold sizes up to TS1_TX_MIN; all other thresholds are smaller.
module lnk_train_fsm
    import lnk_train_pkg::*;
#(
    parameter int FIELD_W     = 8,
    parameter int TS1_TX_MIN  = 1024,
    parameter int TS_RX_MIN   = 8,
    parameter int TS2_TX_MIN  = 16,
    parameter int CFG_CONSEC  = 2,
    parameter int CPL_CONSEC  = 8,
    parameter int IDL_RX_MIN  = 8,
    parameter int IDL_TX_MIN  = 16,
    parameter int DIS_CONSEC  = 2,
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               elec_idle_i,
    input  logic               rx_det_i,
    input  logic               rx_os_valid_i,
    input  logic               rx_os_is_ts2_i,
    input  logic               rx_os_link_pad_i,
    input  logic [FIELD_W-1:0] rx_os_link_i,
    input  logic               rx_os_lane_pad_i,
    input  logic [FIELD_W-1:0] rx_os_lane_i,
    input  logic               rx_os_inv_i,
    input  logic               rx_os_disable_i,
    input  logic               rx_idl_i,
    input  logic               tx_done_i,
    output logic [1:0]         tx_kind_o,
    output logic               tx_link_pad_o,
    output logic [FIELD_W-1:0] tx_link_o,
    output logic               tx_lane_pad_o,
    output logic [FIELD_W-1:0] tx_lane_o,
    output logic               rx_invert_o,
    output logic               link_up_o,
    output logic               disabled_o
);
    localparam int CW = $clog2(TS1_TX_MIN + 1);
    localparam logic [CW-1:0] C_TS1_TX = CW'(TS1_TX_MIN);
    localparam logic [CW-1:0] C_TS_RX  = CW'(TS_RX_MIN);
    localparam logic [CW-1:0] C_TS2_TX = CW'(TS2_TX_MIN);
    localparam logic [CW-1:0] C_CFG    = CW'(CFG_CONSEC);
    localparam logic [CW-1:0] C_CPL    = CW'(CPL_CONSEC);
    localparam logic [CW-1:0] C_IDL_RX = CW'(IDL_RX_MIN);
    localparam logic [CW-1:0] C_IDL_TX = CW'(IDL_TX_MIN);
    localparam logic [CW-1:0] C_DIS    = CW'(DIS_CONSEC);

    lt_state_e state_q, state_d;
    logic [FIELD_W-1:0] link_q, lane_q;
    logic inv_q;

    logic [CW-1:0] rx_cnt, tx_cnt, dis_cnt;
    logic rx_inc, rx_mismatch, tx_inc, adv;
    logic dis_match, dis_clr, timed, tmo;
    logic ev_ts1, ev_ts2;

    assign ev_ts1 = rx_os_valid_i && !rx_os_is_ts2_i;
    assign ev_ts2 = rx_os_valid_i &&  rx_os_is_ts2_i;

    // counting rules and exit condition for the current state
    always_comb begin
        rx_inc      = 1'b0;
        rx_mismatch = 1'b0;
        tx_inc      = 1'b0;
        adv         = 1'b0;
        unique case (state_q)
            ST_POLL_ACTIVE: begin
                rx_inc = ev_ts1;
                tx_inc = tx_done_i;
                adv    = (rx_cnt >= C_TS_RX) && (tx_cnt >= C_TS1_TX);
            end
            ST_POLL_CONFIG: begin
                rx_inc = ev_ts2;
                tx_inc = tx_done_i && (rx_cnt != '0);
                adv    = (rx_cnt >= C_TS_RX) && (tx_cnt >= C_TS2_TX);
            end
            ST_CFG_LW_START: begin
                rx_inc      = ev_ts1 && !rx_os_link_pad_i;
                rx_mismatch = rx_os_valid_i && !rx_inc;
                adv         = (rx_cnt >= C_CFG);
            end
            ST_CFG_LW_ACCEPT: begin
                rx_inc      = ev_ts1 && !rx_os_link_pad_i && !rx_os_lane_pad_i;
                rx_mismatch = rx_os_valid_i && !rx_inc;
                adv         = (rx_cnt >= C_CFG);
            end
            ST_CFG_LN_WAIT: begin
                rx_inc      = ev_ts2;
                rx_mismatch = rx_os_valid_i && !rx_inc;
                adv         = (rx_cnt >= C_CFG);
            end
            ST_CFG_COMPLETE: begin
                rx_inc      = ev_ts2;
                rx_mismatch = rx_os_valid_i && !rx_inc;
                adv         = (rx_cnt >= C_CPL);
            end
            ST_CFG_IDLE: begin
                rx_inc = rx_idl_i;
                tx_inc = tx_done_i && (rx_cnt != '0);
                adv    = (rx_cnt >= C_IDL_RX) && (tx_cnt >= C_IDL_TX);
            end
            default: ;
        endcase
    end

    assign timed = (state_q inside {ST_POLL_ACTIVE, ST_POLL_CONFIG, ST_CFG_LW_START,
                                    ST_CFG_LW_ACCEPT, ST_CFG_LN_WAIT, ST_CFG_COMPLETE,
                                    ST_CFG_IDLE});
    assign dis_match = ev_ts1 && rx_os_disable_i;
    assign dis_clr   = !(timed || state_q == ST_L0) || (rx_os_valid_i && !dis_match);

    // next-state selection: disable first, then timeout, then normal exits
    always_comb begin
        state_d = state_q;
        if ((timed || state_q == ST_L0) && dis_cnt >= C_DIS) begin
            state_d = ST_DISABLED;
        end else if (tmo) begin
            state_d = ST_DET_QUIET;
        end else begin
            unique case (state_q)
                ST_DET_QUIET:     if (!elec_idle_i) state_d = ST_DET_ACTIVE;
                ST_DET_ACTIVE:    state_d = rx_det_i ? ST_POLL_ACTIVE : ST_DET_QUIET;
                ST_POLL_ACTIVE:   if (adv) state_d = ST_POLL_CONFIG;
                ST_POLL_CONFIG:   if (adv) state_d = ST_CFG_LW_START;
                ST_CFG_LW_START:  if (adv) state_d = ST_CFG_LW_ACCEPT;
                ST_CFG_LW_ACCEPT: if (adv) state_d = ST_CFG_LN_WAIT;
                ST_CFG_LN_WAIT:   if (adv) state_d = ST_CFG_COMPLETE;
                ST_CFG_COMPLETE:  if (adv) state_d = ST_CFG_IDLE;
                ST_CFG_IDLE:      if (adv) state_d = ST_L0;
                default:          state_d = state_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_DET_QUIET;
        else        state_q <= state_d;
    end

    // polarity flag and captured link/lane numbers
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_DET_QUIET) begin
            inv_q  <= 1'b0;
            link_q <= '0;
            lane_q <= '0;
        end else begin
            if (state_q == ST_POLL_ACTIVE && ev_ts1 && rx_os_inv_i)
                inv_q <= 1'b1;
            if (state_q == ST_CFG_LW_START && rx_inc)
                link_q <= rx_os_link_i;
            if (state_q == ST_CFG_LW_ACCEPT && rx_inc)
                lane_q <= rx_os_lane_i;
        end
    end

    lt_event_counter #(.WIDTH(CW)) u_rx_cnt (
        .clk(clk), .rst_n(rst_n), .clr((state_d != state_q) || rx_mismatch),
        .inc(rx_inc), .count(rx_cnt));

    lt_event_counter #(.WIDTH(CW)) u_tx_cnt (
        .clk(clk), .rst_n(rst_n), .clr(state_d != state_q),
        .inc(tx_inc), .count(tx_cnt));

    lt_event_counter #(.WIDTH(CW)) u_dis_cnt (
        .clk(clk), .rst_n(rst_n), .clr(dis_clr),
        .inc(dis_match), .count(dis_cnt));

    lt_timer #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clr(state_d != state_q),
        .run(timed), .expired(tmo));

    // transmit request decode
    always_comb begin
        tx_kind_o     = TXK_NONE;
        tx_link_pad_o = 1'b1;
        tx_lane_pad_o = 1'b1;
        tx_link_o     = link_q;
        tx_lane_o     = lane_q;
        unique case (state_q)
            ST_POLL_ACTIVE, ST_CFG_LW_START: tx_kind_o = TXK_TS1;
            ST_POLL_CONFIG:   tx_kind_o = TXK_TS2;
            ST_CFG_LW_ACCEPT: begin
                tx_kind_o     = TXK_TS1;
                tx_link_pad_o = 1'b0;
            end
            ST_CFG_LN_WAIT: begin
                tx_kind_o     = TXK_TS1;
                tx_link_pad_o = 1'b0;
                tx_lane_pad_o = 1'b0;
            end
            ST_CFG_COMPLETE: begin
                tx_kind_o     = TXK_TS2;
                tx_link_pad_o = 1'b0;
                tx_lane_pad_o = 1'b0;
            end
            ST_CFG_IDLE, ST_L0: tx_kind_o = TXK_IDL;
            default: ;
        endcase
    end

    assign rx_invert_o = inv_q;
    assign link_up_o   = (state_q == ST_L0);
    assign disabled_o  = (state_q == ST_DISABLED);
endmodule

// File: rtl/lnk_train_chk.sv
// Temporal checks on the link training controller, bound to its state.
// Assumes: attached through the bind below.
module lnk_train_chk
    import lnk_train_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input lt_state_e state,
    input logic      elec_idle,
    input logic      rx_invert,
    input logic      link_up,
    input logic      disabled
);
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DET_QUIET && elec_idle) |=> state == ST_DET_QUIET); // R1
    AST_QUIET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DET_QUIET && !elec_idle) |=> state == ST_DET_ACTIVE); // R1
    AST_INVERT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_POLL_CONFIG, ST_CFG_LW_START, ST_CFG_LW_ACCEPT,
                       ST_CFG_LN_WAIT, ST_CFG_COMPLETE, ST_CFG_IDLE, ST_L0})
        |=> $stable(rx_invert)); // R3
    AST_LINKUP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(state) == ST_CFG_IDLE); // R8
    AST_DISABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        disabled |=> disabled && !link_up); // R9
endmodule

bind lnk_train_fsm lnk_train_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .elec_idle(elec_idle_i),
    .rx_invert(rx_invert_o), .link_up(link_up_o), .disabled(disabled_o));

// File: tb/lnk_train_fsm_test.sv
// Directed bench for the link training controller: one task per scenario.
module lnk_train_fsm_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       elec_idle_i = 1'b1, rx_det_i = 1'b0;
    logic       rx_os_valid_i = 1'b0, rx_os_is_ts2_i = 1'b0;
    logic       rx_os_link_pad_i = 1'b1, rx_os_lane_pad_i = 1'b1;
    logic [7:0] rx_os_link_i = '0, rx_os_lane_i = '0;
    logic       rx_os_inv_i = 1'b0, rx_os_disable_i = 1'b0;
    logic       rx_idl_i = 1'b0, tx_done_i = 1'b0;
    logic [1:0] tx_kind_o;
    logic       tx_link_pad_o, tx_lane_pad_o;
    logic [7:0] tx_link_o, tx_lane_o;
    logic       rx_invert_o, link_up_o, disabled_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    lnk_train_fsm uut (
        .clk(clk), .rst_n(rst_n), .elec_idle_i(elec_idle_i), .rx_det_i(rx_det_i),
        .rx_os_valid_i(rx_os_valid_i), .rx_os_is_ts2_i(rx_os_is_ts2_i),
        .rx_os_link_pad_i(rx_os_link_pad_i), .rx_os_link_i(rx_os_link_i),
        .rx_os_lane_pad_i(rx_os_lane_pad_i), .rx_os_lane_i(rx_os_lane_i),
        .rx_os_inv_i(rx_os_inv_i), .rx_os_disable_i(rx_os_disable_i),
        .rx_idl_i(rx_idl_i), .tx_done_i(tx_done_i), .tx_kind_o(tx_kind_o),
        .tx_link_pad_o(tx_link_pad_o), .tx_link_o(tx_link_o),
        .tx_lane_pad_o(tx_lane_pad_o), .tx_lane_o(tx_lane_o),
        .rx_invert_o(rx_invert_o), .link_up_o(link_up_o), .disabled_o(disabled_o));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // compare the whole transmit request: kind, link pad, link, lane pad, lane
    task automatic chk_tx(input string req, input logic [1:0] k, input logic lp,
                          input logic [7:0] l, input logic np, input logic [7:0] n);
        chk({req, " kind"}, 32'(tx_kind_o), 32'(k));
        chk({req, " linkpad"}, 32'(tx_link_pad_o), 32'(lp));
        chk({req, " lanepad"}, 32'(tx_lane_pad_o), 32'(np));
        if (!lp) chk({req, " link"}, 32'(tx_link_o), 32'(l));
        if (!np) chk({req, " lane"}, 32'(tx_lane_o), 32'(n));
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // one received ordered set, valid for one clock
    task automatic os(input bit ts2, input bit lpad, input logic [7:0] link,
                      input bit npad, input logic [7:0] lane, input bit inv, input bit dis);
        @(negedge clk);
        rx_os_valid_i = 1'b1; rx_os_is_ts2_i = ts2;
        rx_os_link_pad_i = lpad; rx_os_link_i = link;
        rx_os_lane_pad_i = npad; rx_os_lane_i = lane;
        rx_os_inv_i = inv; rx_os_disable_i = dis;
        @(negedge clk);
        rx_os_valid_i = 1'b0; rx_os_inv_i = 1'b0; rx_os_disable_i = 1'b0;
    endtask

    task automatic txd(input int n);
        @(negedge clk);
        tx_done_i = 1'b1;
        repeat (n) @(negedge clk);
        tx_done_i = 1'b0;
    endtask

    task automatic idl(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_idl_i = 1'b1;
            @(negedge clk); rx_idl_i = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; elec_idle_i = 1'b1; rx_det_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R12 kind", 32'(tx_kind_o), 32'd0);
        chk("R12 linkup", 32'(link_up_o), 32'd0);
        chk("R12 disabled", 32'(disabled_o), 32'd0);
        chk("R12 invert", 32'(rx_invert_o), 32'd0);
    endtask

    task automatic t_detect();
        repeat (20) @(negedge clk);
        chk("R1 idle hold", 32'(tx_kind_o), 32'd0);
        elec_idle_i = 1'b0; rx_det_i = 1'b0;
        repeat (10) @(negedge clk);
        chk("R1 no receiver", 32'(tx_kind_o), 32'd0);
        rx_det_i = 1'b1;
        settle();
        chk_tx("R1 to polling", 2'd1, 1'b1, 8'd0, 1'b1, 8'd0);
    endtask

    task automatic t_polling();
        for (int i = 0; i < 7; i++) os(1'b0, 1'b1, 8'd0, 1'b1, 8'd0, i[0], 1'b0);
        txd(1023);
        settle();
        chk_tx("R2 short sends", 2'd1, 1'b1, 8'd0, 1'b1, 8'd0);
        txd(1);
        settle();
        chk_tx("R2 short receives", 2'd1, 1'b1, 8'd0, 1'b1, 8'd0);
        os(1'b0, 1'b1, 8'd0, 1'b1, 8'd0, 1'b0, 1'b0);
        settle();
        chk_tx("R2 to poll config", 2'd2, 1'b1, 8'd0, 1'b1, 8'd0);
        chk("R3 invert set", 32'(rx_invert_o), 32'd1);
    endtask

    task automatic t_poll_cfg();
        txd(20);
        os(1'b1, 1'b1, 8'd0, 1'b1, 8'd0, 1'b0, 1'b0);
        txd(15);
        for (int i = 0; i < 7; i++) os(1'b1, 1'b1, 8'd0, 1'b1, 8'd0, 1'b0, 1'b0);
        settle();
        chk_tx("R4 early sends ignored", 2'd2, 1'b1, 8'd0, 1'b1, 8'd0);
        txd(1);
        settle();
        chk_tx("R4 to width start", 2'd1, 1'b1, 8'd0, 1'b1, 8'd0);
    endtask

    task automatic t_config();
        os(1'b0, 1'b0, 8'd5, 1'b1, 8'd0, 1'b0, 1'b0);
        os(1'b1, 1'b1, 8'd0, 1'b1, 8'd0, 1'b0, 1'b0);
        os(1'b0, 1'b0, 8'd5, 1'b1, 8'd0, 1'b0, 1'b0);
        settle();
        chk_tx("R11 width start restart", 2'd1, 1'b1, 8'd0, 1'b1, 8'd0);
        os(1'b0, 1'b0, 8'd5, 1'b1, 8'd0, 1'b0, 1'b0);
        settle();
        chk_tx("R5 link echoed", 2'd1, 1'b0, 8'd5, 1'b1, 8'd0);
        os(1'b0, 1'b0, 8'd5, 1'b0, 8'd3, 1'b0, 1'b0);
        os(1'b0, 1'b0, 8'd5, 1'b0, 8'd3, 1'b0, 1'b0);
        settle();
        chk_tx("R6 lane echoed", 2'd1, 1'b0, 8'd5, 1'b0, 8'd3);
        os(1'b1, 1'b0, 8'd5, 1'b0, 8'd3, 1'b0, 1'b0);
        os(1'b1, 1'b0, 8'd5, 1'b0, 8'd3, 1'b0, 1'b0);
        settle();
        chk_tx("R6 to complete", 2'd2, 1'b0, 8'd5, 1'b0, 8'd3);
        for (int i = 0; i < 7; i++) os(1'b1, 1'b0, 8'd5, 1'b0, 8'd3, 1'b0, 1'b0);
        os(1'b0, 1'b0, 8'd5, 1'b0, 8'd3, 1'b0, 1'b0);
        for (int i = 0; i < 7; i++) os(1'b1, 1'b0, 8'd5, 1'b0, 8'd3, 1'b0, 1'b0);
        settle();
        chk("R11 complete restart", 32'(tx_kind_o), 32'd2);
        os(1'b1, 1'b0, 8'd5, 1'b0, 8'd3, 1'b0, 1'b0);
        settle();
        chk("R7 idle symbols", 32'(tx_kind_o), 32'd3);
        chk("R7 not up yet", 32'(link_up_o), 32'd0);
    endtask

    task automatic t_idle();
        txd(10);
        idl(1);
        txd(15);
        idl(7);
        settle();
        chk("R8 one send short", 32'(link_up_o), 32'd0);
        txd(1);
        settle();
        chk("R8 link up", 32'(link_up_o), 32'd1);
        chk("R8 idle kind", 32'(tx_kind_o), 32'd3);
        chk("R3 invert kept", 32'(rx_invert_o), 32'd1);
    endtask

    task automatic t_disable();
        do_reset();
        elec_idle_i = 1'b0; rx_det_i = 1'b1;
        settle();
        os(1'b0, 1'b1, 8'd0, 1'b1, 8'd0, 1'b0, 1'b1);
        os(1'b0, 1'b1, 8'd0, 1'b1, 8'd0, 1'b0, 1'b0);
        os(1'b0, 1'b1, 8'd0, 1'b1, 8'd0, 1'b0, 1'b1);
        settle();
        chk("R9 R11 not consecutive", 32'(disabled_o), 32'd0);
        os(1'b0, 1'b1, 8'd0, 1'b1, 8'd0, 1'b0, 1'b1);
        settle();
        chk("R9 disabled", 32'(disabled_o), 32'd1);
        chk("R9 sends nothing", 32'(tx_kind_o), 32'd0);
        repeat (20) @(negedge clk);
        chk("R9 stays disabled", 32'(disabled_o), 32'd1);
    endtask

    task automatic t_timeout();
        do_reset();
        elec_idle_i = 1'b0; rx_det_i = 1'b1;
        settle();
        elec_idle_i = 1'b1;
        repeat (3900) @(negedge clk);
        chk("R10 before expiry", 32'(tx_kind_o), 32'd1);
        repeat (300) @(negedge clk);
        chk("R10 back to quiet", 32'(tx_kind_o), 32'd0);
        chk("R10 invert clear", 32'(rx_invert_o), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_detect();
        t_polling();
        t_poll_cfg();
        t_config();
        t_idle();
        t_disable();
        t_timeout();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule